// File: doc/BRIEF.md
# I2C Target Engine with Event Status

This block answers as a target on a two-wire I2C bus. Software programs a 7-bit own address and a control word through a small register port. The engine then watches the bus, acknowledges its own address (and, if enabled, the general-call address), and moves data bytes through one shared data register. In the other direction, software loads that register with the next byte to send.

Every bus event sets its own bit in a sticky status register. Software clears a bit by writing 0 to it; writing 1 leaves the bit alone. An enable register with the same layout selects which status bits raise the interrupt line. A STOP seen on the bus is flagged even when the transfer was addressed to another target. While a received byte or a transmit-refill request is still pending, the engine holds SCL low. SCL and SDA are open-drain: each is an input plus a pull-low enable.

Register offsets on `reg_sel`: 0 control, 1 status, 2 interrupt enable, 3 own address, 4 data. Any other offset reads 0.

Top module: `i2c_target_core`

## Requirements
- R1: After reset, every register reads 0, `irq` is low, and both `scl_oe` and `sda_oe` are low.
- R2: With control bit 2 (enable) set and a nonzero own address (offset 3, bits 6:0) equal to the received address, the address byte is answered with ACK and status bit 0 sets. A different address, or control bit 2 clear, gives NACK and leaves status bit 0 clear.
- R3: An own-address value of 0 turns off own-address matching.
- R4: With control bit 1 set, the address byte 0x00 is ACKed and status bits 0 and 6 set. With control bit 1 clear, the address byte 0x00 gets NACK.
- R5: In a write transfer, each data byte is ACKed, stored in the data register (offset 4) and sets status bit 1.
- R6: While control bit 0 is set, the next received data byte is still stored and still sets status bit 1, but it is answered with NACK.
- R7: An address match with the R/W bit at 1 sets status bit 5. Each byte is taken from the data register and shifted out MSB first. Each take sets status bit 3, and the byte is taken only while status bit 3 is clear. Status bit 2 sets at the controller's acknowledge bit after each byte.
- R8: `scl_oe` holds SCL low after a received byte until status bit 1 is cleared. Before the next transmit byte it holds SCL low until status bit 3 is cleared.
- R9: Status bit 4 sets on every STOP condition on the bus, including STOPs that end transfers to other targets.
- R10: Writing the status register clears each bit written as 0 and keeps each bit written as 1.
- R11: `irq` is high exactly when some status bit and the same bit of the enable register (offset 2) are both 1.
- R12: Control bits 3:0 read back as written. Bit 3 (buffer select) is stored and has no effect on transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench plays a stretch-aware bus controller on a wired-AND bus and goes after these corner cases:
- A zero own address and a general-call byte with general call disabled. A design that compared addresses blindly would ACK these.
- A forced NACK. A design that skipped the byte store would lose the data; one that ignored the bit would ACK.
- A STOP after an unmatched address. A design that gated stop detection on its own match would miss it.
- Clearing a single status flag while the others stay set. A design that cleared the whole register on a write would drop them.
- In reads, the refill handshake. If status bit 3 or SCL stretching were wrong, the controller would see stale bytes or a bus that never stalls.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;
    localparam int STAT_W = 7;
    localparam int CTRL_W = 4;
    localparam int SEL_W  = 3;

    // status / interrupt-enable bit positions
    localparam int ST_ADDR = 0;
    localparam int ST_RXB  = 1;
    localparam int ST_TXD  = 2;
    localparam int ST_REFL = 3;
    localparam int ST_STOP = 4;
    localparam int ST_RDM  = 5;
    localparam int ST_GEN  = 6;

    // control bit positions
    localparam int CT_NACK = 0;
    localparam int CT_GCEN = 1;
    localparam int CT_EN   = 2;
    localparam int CT_BUF  = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd1;
    localparam logic [SEL_W-1:0] SEL_IEN  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_OWN  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DATA = 3'd4;

    typedef enum logic [3:0] {
        LK_IDLE, LK_ADDR, LK_AACK, LK_RXB, LK_RACK,
        LK_RHOLD, LK_TLOAD, LK_TXB, LK_TACK
    } link_st_t;
endpackage

// File: rtl/i2c_target_sync.sv
module i2c_target_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_ff   = {q.scl_ff[STAGES-2:0], scl_i};
        d.sda_ff   = {q.sda_ff[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_ff[STAGES-1];
        d.sda_prev = q.sda_ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_ff[STAGES-1];
    assign sda_s     = q.sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;

    // R9
    stop_start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |-> !start_det);
endmodule

// File: rtl/i2c_target_link.sv
module i2c_target_link
    import i2c_target_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                cfg_en,
    input  logic                cfg_gcen,
    input  logic                cfg_fnack,
    input  logic [DATA_W-2:0]   own_addr,
    input  logic [DATA_W-1:0]   tx_data,
    input  logic                refill_flag,
    input  logic                rxb_flag,
    output logic [STAT_W-1:0]   ev,
    output logic                rx_we,
    output logic [DATA_W-1:0]   rx_byte,
    output logic                scl_oe,
    output logic                sda_oe
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        link_st_t          st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              rw;
        logic              nak;
        logic              scl_oe;
        logic              sda_oe;
    } link_t;

    link_t q, d;
    logic [DATA_W-1:0] byte_in;
    logic hit_own, hit_gc;

    assign byte_in = {q.sh[DATA_W-2:0], sda_s};
    assign hit_own = cfg_en && (own_addr != '0) && (byte_in[DATA_W-1:1] == own_addr);
    assign hit_gc  = cfg_en && cfg_gcen && (byte_in == '0);

    always_comb begin
        d     = q;
        ev    = '0;
        rx_we = 1'b0;
        if (stop_det) begin
            d.st = LK_IDLE; d.scl_oe = 1'b0; d.sda_oe = 1'b0;
            ev[ST_STOP] = 1'b1;
        end else if (start_det) begin
            d.st = LK_ADDR; d.cnt = '0; d.scl_oe = 1'b0; d.sda_oe = 1'b0;
        end else begin
            case (q.st)
                LK_ADDR: if (scl_rise) begin
                    d.sh  = byte_in;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        if (hit_own || hit_gc) begin
                            d.st = LK_AACK; d.cnt = '0; d.rw = sda_s;
                            ev[ST_ADDR] = 1'b1;
                            ev[ST_GEN]  = hit_gc;
                            ev[ST_RDM]  = sda_s;
                        end else begin
                            d.st = LK_IDLE;
                        end
                    end
                end
                LK_AACK: if (scl_fall) begin
                    if (q.cnt == '0) begin
                        d.sda_oe = 1'b1; d.cnt = 1;
                    end else begin
                        d.sda_oe = 1'b0; d.cnt = '0;
                        d.st = q.rw ? LK_TLOAD : LK_RXB;
                    end
                end
                LK_RXB: if (scl_rise) begin
                    d.sh  = byte_in;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.st = LK_RACK; d.cnt = '0;
                    end
                end
                LK_RACK: if (scl_fall) begin
                    if (q.cnt == '0) begin
                        rx_we = 1'b1;
                        ev[ST_RXB] = 1'b1;
                        d.sda_oe = ~cfg_fnack;
                        d.nak = cfg_fnack;
                        d.cnt = 1;
                    end else begin
                        d.sda_oe = 1'b0; d.cnt = '0;
                        if (q.nak) d.st = LK_IDLE;
                        else begin
                            d.st = LK_RHOLD; d.scl_oe = rxb_flag;
                        end
                    end
                end
                LK_RHOLD: begin
                    if (!rxb_flag) begin
                        d.scl_oe = 1'b0; d.st = LK_RXB; d.cnt = '0;
                    end else begin
                        d.scl_oe = 1'b1;
                    end
                end
                LK_TLOAD: begin
                    if (refill_flag) begin
                        d.scl_oe = 1'b1;
                    end else begin
                        d.scl_oe = 1'b0;
                        d.sh = tx_data;
                        d.sda_oe = ~tx_data[DATA_W-1];
                        d.cnt = '0;
                        d.st = LK_TXB;
                        ev[ST_REFL] = 1'b1;
                    end
                end
                LK_TXB: if (scl_fall) begin
                    if (q.cnt == LAST) begin
                        d.sda_oe = 1'b0; d.st = LK_TACK;
                    end else begin
                        d.sh = {q.sh[DATA_W-2:0], 1'b0};
                        d.sda_oe = ~q.sh[DATA_W-2];
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                LK_TACK: begin
                    if (scl_rise) begin
                        d.nak = sda_s;
                        ev[ST_TXD] = 1'b1;
                    end else if (scl_fall) begin
                        d.st = q.nak ? LK_IDLE : LK_TLOAD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: LK_IDLE, default: '0};
        else        q <= d;
    end

    assign rx_byte = q.sh;
    assign scl_oe  = q.scl_oe;
    assign sda_oe  = q.sda_oe;

    // R8
    stretch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !$past(scl_s));
    // R2
    match_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[ST_ADDR] |-> cfg_en);
    // R5
    sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(stop_det) || $past(start_det)));
endmodule

// File: rtl/i2c_target_regs.sv
module i2c_target_regs
    import i2c_target_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [STAT_W-1:0]   ev,
    input  logic                rx_we,
    input  logic [DATA_W-1:0]   rx_byte,
    output logic [CTRL_W-1:0]   ctrl,
    output logic [DATA_W-2:0]   own_addr,
    output logic [DATA_W-1:0]   data,
    output logic [STAT_W-1:0]   stat,
    output logic                irq
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] ien;
        logic [DATA_W-2:0] own;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_sel)
                SEL_CTRL: d.ctrl = reg_wdata[CTRL_W-1:0];
                SEL_STAT: d.stat = q.stat & reg_wdata[STAT_W-1:0];
                SEL_IEN:  d.ien  = reg_wdata[STAT_W-1:0];
                SEL_OWN:  d.own  = reg_wdata[DATA_W-2:0];
                SEL_DATA: d.data = reg_wdata;
                default: ;
            endcase
        end
        d.stat = d.stat | ev;
        if (rx_we) d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: reg_rdata[CTRL_W-1:0] = q.ctrl;
            SEL_STAT: reg_rdata[STAT_W-1:0] = q.stat;
            SEL_IEN:  reg_rdata[STAT_W-1:0] = q.ien;
            SEL_OWN:  reg_rdata[DATA_W-2:0] = q.own;
            SEL_DATA: reg_rdata = q.data;
            default: ;
        endcase
    end

    assign ctrl     = q.ctrl;
    assign own_addr = q.own;
    assign data     = q.data;
    assign stat     = q.stat;
    assign irq      = |(q.stat & q.ien);

    for (genvar i = 0; i < STAT_W; i++) begin : g_stat_chk
        // R10
        stat_w0c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(q.stat[i]) |-> $past(reg_wr && reg_sel == SEL_STAT && !reg_wdata[i]));
    end

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr));
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
    import i2c_target_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              scl_i,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_oe
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [STAT_W-1:0] ev, stat;
    logic rx_we;
    logic [DATA_W-1:0] rx_byte, data;
    logic [CTRL_W-1:0] ctrl;
    logic [DATA_W-2:0] own_addr;

    i2c_target_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_link #(.DATA_W(DATA_W)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .cfg_en(ctrl[CT_EN]), .cfg_gcen(ctrl[CT_GCEN]), .cfg_fnack(ctrl[CT_NACK]),
        .own_addr(own_addr), .tx_data(data),
        .refill_flag(stat[ST_REFL]), .rxb_flag(stat[ST_RXB]),
        .ev(ev), .rx_we(rx_we), .rx_byte(rx_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    i2c_target_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev(ev), .rx_we(rx_we), .rx_byte(rx_byte),
        .ctrl(ctrl), .own_addr(own_addr), .data(data), .stat(stat), .irq(irq)
    );
endmodule

// File: tb/i2c_target_core_tb_top.sv
`timescale 1ns/1ps
module i2c_target_core_tb_top;
    localparam int Q = 10;
    localparam logic [2:0] O_CTRL = 3'd0, O_STAT = 3'd1, O_IEN = 3'd2, O_OWN = 3'd3, O_DATA = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_sel = '0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_bus, sda_bus;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_target_core dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_bus), .scl_oe(scl_oe), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] w0c(input logic [7:0] cur, input logic [7:0] w);
        return cur & w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic rw(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk); reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rr(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk); reg_sel = s; #1; v = reg_rdata;
    endtask

    task automatic xbit(input logic b, output logic r);
        scl_m = 1'b0; wq(); sda_m = b; wq(); scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        wq(); r = sda_bus; wq(); scl_m = 1'b0;
    endtask

    task automatic bstart();
        sda_m = 1'b1; wq(); scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        wq(); sda_m = 1'b0; wq();
    endtask

    task automatic bstop();
        scl_m = 1'b0; wq(); sda_m = 1'b0; wq(); scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        wq(); sda_m = 1'b1; wq();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xbit(b[i], r);
        xbit(1'b1, ack);
    endtask

    task automatic rbyte(input logic nak, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin xbit(1'b1, r); b[i] = r; end
        xbit(nak, r);
    endtask

    initial begin
        logic [7:0] v, st, rb;
        logic a;
        int seed;
        seed = $urandom(32'h5EED1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 5; s++) begin rr(3'(s), v); chk("R1 reg", v, 0); end
        chk("R1 irq", irq, 0); chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);

        // R12 control readback
        rw(O_CTRL, 8'h0F); rr(O_CTRL, v); chk("R12 ctrl", v, 8'h0F);
        rw(O_CTRL, 8'h08); rr(O_CTRL, v); chk("R12 bit3", v, 8'h08);
        rw(O_CTRL, 8'h0C);

        // R3 own address zero: nothing matches
        bstart(); wbyte(8'h54, a); chk("R3 nack", a, 1); bstop();
        bstart(); wbyte(8'h00, a); chk("R3 gc off nack", a, 1); bstop();
        rr(O_STAT, v); chk("R3 R9 stat", v, 8'h10);
        rw(O_STAT, 8'h00);

        // R2 R5 R8 R10 write transfer with random data
        rw(O_OWN, 8'h2A);
        bstart(); wbyte(8'h54, a); chk("R2 ack", a, 0);
        rr(O_STAT, v); chk("R2 stat", v, 8'h01);
        for (int k = 0; k < 6; k++) begin
            rb = 8'($urandom);
            wbyte(rb, a); chk("R5 ack", a, 0);
            rr(O_DATA, v); chk("R5 data", v, rb);
            rr(O_STAT, st); chk("R5 flag", st[1], 1);
            repeat (5) @(negedge clk); chk("R8 rx stretch", scl_oe, 1);
            rw(O_STAT, 8'hFD); rr(O_STAT, v); chk("R10 single clear", v, w0c(st, 8'hFD));
            repeat (4) @(negedge clk); chk("R8 rx release", scl_oe, 0);
        end
        // R6 forced NACK
        rw(O_CTRL, 8'h0D);
        rb = 8'($urandom);
        wbyte(rb, a); chk("R6 nack", a, 1);
        rr(O_DATA, v); chk("R6 data", v, rb);
        rr(O_STAT, v); chk("R6 flag", v[1], 1);
        repeat (5) @(negedge clk); chk("R6 no stretch", scl_oe, 0);
        bstop(); rw(O_CTRL, 8'h04);
        rr(O_STAT, v); chk("R9 own stop", v[4], 1);
        rw(O_STAT, 8'h00);

        // R2 R9 other target
        bstart(); wbyte(8'h56, a); chk("R2 mismatch nack", a, 1); bstop();
        rr(O_STAT, v); chk("R9 foreign stop", v, 8'h10);
        // R10 writing ones keeps flags
        rw(O_STAT, 8'hFF); rr(O_STAT, v); chk("R10 ones", v, 8'h10);
        rw(O_STAT, 8'h00);
        rw(O_CTRL, 8'h00);
        bstart(); wbyte(8'h54, a); chk("R2 disabled nack", a, 1); bstop();
        rr(O_STAT, v); chk("R2 disabled stat", v[0], 0);
        rw(O_STAT, 8'h00);

        // R4 general call
        rw(O_CTRL, 8'h06);
        bstart(); wbyte(8'h00, a); chk("R4 gc ack", a, 0);
        rr(O_STAT, v); chk("R4 gc stat", v, 8'h41);
        wbyte(8'h3C, a); rr(O_DATA, v); chk("R4 gc data", v, 8'h3C);
        rw(O_STAT, 8'h00); bstop();
        rw(O_CTRL, 8'h04); rw(O_STAT, 8'h00);
        bstart(); wbyte(8'h00, a); chk("R4 gc off", a, 1); bstop();
        rw(O_STAT, 8'h00);

        // R7 R8 read transfer
        rb = 8'($urandom);
        rw(O_DATA, rb);
        bstart(); wbyte(8'h55, a); chk("R7 addr ack", a, 0);
        rbyte(1'b0, v); chk("R7 first byte", v, rb);
        rr(O_STAT, v); chk("R7 stat", v, 8'h2D);
        repeat (5) @(negedge clk); chk("R8 tx stretch", scl_oe, 1);
        for (int k = 0; k < 4; k++) begin
            rb = 8'($urandom);
            rw(O_DATA, rb); rw(O_STAT, 8'hF3);
            repeat (4) @(negedge clk); chk("R8 tx release", scl_oe, 0);
            rbyte(k == 3, v); chk("R7 byte", v, rb);
            rr(O_STAT, v); chk("R7 sent flag", v[2], 1);
        end
        bstop(); rw(O_STAT, 8'h00);

        // R11 interrupt gating
        rw(O_IEN, 8'h02);
        bstart(); wbyte(8'h54, a);
        repeat (2) @(negedge clk); chk("R11 masked", irq, 0);
        wbyte(8'h11, a); repeat (2) @(negedge clk); chk("R11 raised", irq, 1);
        rw(O_STAT, 8'hFD); repeat (2) @(negedge clk); chk("R11 cleared", irq, 0);
        rw(O_IEN, 8'h00);
        wbyte(8'h22, a); repeat (2) @(negedge clk); chk("R11 disabled", irq, 0);
        rw(O_STAT, 8'hFD); bstop();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule